// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Scheduler

This block keeps an asynchronous DRAM refreshed and brings it out of reset. After reset it waits out a power-up pause, then runs a burst of eight refresh cycles before it lets normal accesses start. From then on a free-running interval timer marks refreshes as owed. The block asks the access sequencer for the DRAM pins over a request/grant pair. While it holds the grant it drives the row strobe, both column strobes, the write strobe and the address pins itself.

Each refresh takes one of two forms, chosen by a mode input that is sampled when the cycle starts. In the column-first form, both column strobes fall before the row strobe and the DRAM supplies the row itself. In the row-address form, the block drives the row from its own 8-bit counter and pulses only the row strobe. If the sequencer withholds the grant long enough that an owed refresh is postponed past a limit, the block flags the missed deadline. It then withdraws readiness and repeats the eight-cycle wake-up burst once it gets the pins back. All times are counts of the system clock and are set by parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset is released, `bus_req` stays low and all strobes stay high for exactly `PAUSE_CYC` clock cycles. `bus_req` rises in the next cycle, and `ready` stays low throughout.
- R2: After the pause the block runs exactly `WAKE_CNT` refreshes back to back and holds `bus_req` high from the first to the last. `ready` rises in the cycle in which `bus_req` falls.
- R3: With the grant always given and the mode constant, successive row-strobe falls are exactly `REF_INTERVAL` cycles apart.
- R4: Strobes go low only while `bus_gnt` is high. While the grant is withheld, `bus_req` stays high and the row strobe stays high.
- R5: In column-first mode (`cbr_mode`=1), both column strobes are low for `T_CSR` cycles before the row strobe falls and stay low for `T_CHR` cycles after it. The write strobe is high at the row-strobe fall. The row strobe is low for `T_RAS` cycles.
- R6: In row-address mode (`cbr_mode`=0), both column strobes stay high throughout. `addr` carries the row counter while the row strobe is low, and the row strobe is low for `T_RAS` cycles.
- R7: The row counter starts at 0 and advances by one after each row-address refresh, wrapping from 255 to 0. Column-first refreshes leave it unchanged.
- R8: Between back-to-back refreshes, the row strobe stays high for `max(T_RP,T_RPC)` cycles plus the setup phase (1 cycle in row-address mode, `T_CSR` in column-first mode). Column strobes never fall sooner than `T_RPC` cycles after the row strobe rises.
- R9: If an owed refresh remains ungranted for `LATE_LIMIT` cycles, `late` rises and `ready` falls. Once the grant arrives, `WAKE_CNT` refreshes run under one request, after which `late` falls and `ready` rises.
- R10: The mode is sampled when a refresh cycle starts. A change of `cbr_mode` during a cycle takes effect only at the next cycle.
- R11: The configured counts, at a 20 ns clock, meet these limits: at least 40 ns row-strobe low, 30 ns precharge, 10 ns column-strobe setup and hold, at most 15.6 µs between refreshes, and a pause of at least 200 µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cbr_mode | input | 1 | 1: column-first refresh, 0: row-address refresh |
| bus_gnt | input | 1 | DRAM pins granted by the access sequencer |
| bus_req | output | 1 | Request for the DRAM pins, held until the refresh work is done |
| ready | output | 1 | Wake-up finished, normal accesses allowed |
| late | output | 1 | Refresh deadline missed, wake-up burst pending |
| ras_n | output | 1 | Row strobe, active low |
| casl_n | output | 1 | Lower column strobe, active low |
| cash_n | output | 1 | Upper column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| addr | output | ROW_W | Row address in row-address mode, else zero |

## Verification
The request rises `PAUSE_CYC+1` clock edges after reset is released, and the bench checks that exact edge. With the grant tied to the request, each row-strobe fall follows the timer tick by a fixed number of edges, so fall-to-fall spacing is compared for equality with `REF_INTERVAL`. The `late` flag is due `LATE_LIMIT-1` edges after the request is first seen, and the bench accepts one cycle either side. The bench samples 2 ns after the falling clock edge. Pulse widths and leads are counted sample by sample over whole pulses, so each strobe phase is compared with its exact parameter value.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned PAUSE_CYC    = 10000,
  parameter int unsigned REF_INTERVAL = 780,
  parameter int unsigned LATE_LIMIT   = 1560,
  parameter int unsigned WAKE_CNT     = 8,
  parameter int unsigned ROW_W        = 8,
  parameter int unsigned T_RAS        = 3,
  parameter int unsigned T_RP         = 2,
  parameter int unsigned T_RPC        = 1,
  parameter int unsigned T_CSR        = 1,
  parameter int unsigned T_CHR        = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cbr_mode,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             ready,
  output logic             late,
  output logic             ras_n,
  output logic             casl_n,
  output logic             cash_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr
);

  localparam int unsigned T_PRE = (T_RP > T_RPC) ? T_RP : T_RPC;
  localparam int unsigned CW = $clog2(PAUSE_CYC + T_RAS + T_PRE + T_CSR + T_CHR + 1);
  localparam int unsigned TW = $clog2(REF_INTERVAL + 1);
  localparam int unsigned LW = $clog2(LATE_LIMIT + 1);
  localparam int unsigned WW = $clog2(WAKE_CNT + 1);

  typedef enum logic [2:0] {
    S_PAUSE, S_IDLE, S_REQ, S_SETUP, S_HOLD, S_RAS, S_PRE
  } st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   tmr;
  logic [LW-1:0]   wait_cnt;
  logic [WW-1:0]   wake_left;
  logic [ROW_W-1:0] row;
  logic            pending, mode_q;

  logic own, tick, waiting, cycle_done, strobe_cas;

  assign own        = (st == S_SETUP) || (st == S_HOLD) || (st == S_RAS) || (st == S_PRE);
  assign tick       = (st != S_PAUSE) && (tmr == TW'(REF_INTERVAL - 1));
  assign waiting    = pending && !late && ((st == S_IDLE) || (st == S_REQ));
  assign cycle_done = (st == S_PRE) && (cnt == '0);
  assign strobe_cas = mode_q && ((st == S_SETUP) || (st == S_HOLD));

  assign bus_req = (st == S_REQ) || own;
  assign ready   = (wake_left == '0);
  assign ras_n   = !((st == S_HOLD) || (st == S_RAS));
  assign casl_n  = !strobe_cas;
  assign cash_n  = !strobe_cas;
  assign we_n    = 1'b1;
  assign addr    = (own && !mode_q) ? row : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PAUSE;
      cnt       <= CW'(PAUSE_CYC - 1);
      tmr       <= '0;
      wait_cnt  <= '0;
      wake_left <= WW'(WAKE_CNT);
      row       <= '0;
      pending   <= 1'b0;
      mode_q    <= 1'b0;
      late      <= 1'b0;
    end else begin
      if (st != S_PAUSE) tmr <= tick ? '0 : tmr + 1'b1;

      if (cycle_done) begin
        pending  <= 1'b0;
        wait_cnt <= '0;
        if (!mode_q) row <= row + 1'b1;
        if (wake_left != '0) wake_left <= wake_left - 1'b1;
        if (wake_left == WW'(1)) late <= 1'b0;
      end else if (waiting) begin
        if (wait_cnt == LW'(LATE_LIMIT - 1)) begin
          late      <= 1'b1;
          wake_left <= WW'(WAKE_CNT);
        end else begin
          wait_cnt <= wait_cnt + 1'b1;
        end
      end
      if (tick) pending <= 1'b1;

      case (st)
        S_PAUSE: if (cnt == '0) st <= S_IDLE; else cnt <= cnt - 1'b1;
        S_IDLE:  if (pending || wake_left != '0) st <= S_REQ;
        S_REQ:   if (bus_gnt) begin
                   mode_q <= cbr_mode;
                   cnt    <= cbr_mode ? CW'(T_CSR - 1) : '0;
                   st     <= S_SETUP;
                 end
        S_SETUP: if (cnt != '0) cnt <= cnt - 1'b1;
                 else if (mode_q) begin
                   st  <= S_HOLD;
                   cnt <= CW'(T_CHR - 1);
                 end else begin
                   st  <= S_RAS;
                   cnt <= CW'(T_RAS - 1);
                 end
        S_HOLD:  if (cnt != '0) cnt <= cnt - 1'b1;
                 else begin
                   st  <= S_RAS;
                   cnt <= CW'(T_RAS - T_CHR - 1);
                 end
        S_RAS:   if (cnt != '0) cnt <= cnt - 1'b1;
                 else begin
                   st  <= S_PRE;
                   cnt <= CW'(T_PRE - 1);
                 end
        S_PRE:   if (cnt != '0) cnt <= cnt - 1'b1;
                 else if (wake_left > WW'(1)) begin
                   mode_q <= cbr_mode;
                   cnt    <= cbr_mode ? CW'(T_CSR - 1) : '0;
                   st     <= S_SETUP;
                 end else begin
                   st <= S_IDLE;
                 end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_gnt,
  input logic bus_req,
  input logic ready,
  input logic late,
  input logic ras_n,
  input logic casl_n,
  input logic cash_n
);

  a_r4_pins_need_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_gnt |-> (ras_n && casl_n && cash_n));

  a_r4_release_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> (ras_n && casl_n && cash_n));

  a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !casl_n) |-> $past(!casl_n && ras_n));

  a_r5_cas_pair: assert property (@(posedge clk) disable iff (!rst_n)
    casl_n == cash_n);

  a_r2_ready_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !bus_req);

  a_r9_late_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    late |-> !ready);

endmodule

bind dram_refresh_sched dram_refresh_sched_chk u_chk (.*);

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int P_PAUSE = 10000, P_INT = 200, P_LATE = 400, P_WAKE = 8;
  localparam int P_RAS = 4, P_RP = 2, P_RPC = 1, P_CSR = 2, P_CHR = 2;
  localparam int T_PRE = (P_RP > P_RPC) ? P_RP : P_RPC;

  logic clk = 0, rst_n = 0, cbr_mode = 0, allow = 1;
  logic bus_gnt, bus_req, ready, late, ras_n, casl_n, cash_n, we_n;
  logic [7:0] addr;
  assign bus_gnt = bus_req & allow;
  always #10 clk = ~clk;

  dram_refresh_sched #(.PAUSE_CYC(P_PAUSE), .REF_INTERVAL(P_INT), .LATE_LIMIT(P_LATE),
    .WAKE_CNT(P_WAKE), .ROW_W(8), .T_RAS(P_RAS), .T_RP(P_RP), .T_RPC(P_RPC),
    .T_CSR(P_CSR), .T_CHR(P_CHR)) uut (
    .clk(clk), .rst_n(rst_n), .cbr_mode(cbr_mode), .bus_gnt(bus_gnt), .bus_req(bus_req),
    .ready(ready), .late(late), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
    .we_n(we_n), .addr(addr));

  int n_chk = 0, n_err = 0;
  int cyc = 0, n_fall = 0, n_cbr = 0, n_ro = 0, n_req_drop = 0, last_spacing = 0, last_fall_cyc = 0;
  int bad_ras = 0, bad_lead = 0, bad_hold = 0, bad_pre = 0, bad_rpc = 0, bad_we = 0, bad_cas_ro = 0, row_err = 0;
  int lo_len = 0, hi_len = 0, lead = 0, hold = 0;
  logic [7:0] exp_row = 0, last_ro_addr = 0;
  bit seen_wrap = 0, prev_ras = 1, prev_req = 0, in_cbr = 0, b2b = 0;

  always @(negedge clk) begin
    cyc++;
    if (prev_req && !bus_req) n_req_drop++;
    if (!bus_req) b2b = 0;
    if (!ras_n) begin
      if (prev_ras) begin
        n_fall++; last_spacing = cyc - last_fall_cyc; last_fall_cyc = cyc;
        if (!we_n) bad_we++;
        in_cbr = !casl_n;
        if (in_cbr) begin
          n_cbr++;
          if (lead != P_CSR) bad_lead++;
          if (hi_len - lead < P_RPC) bad_rpc++;
          if (b2b && hi_len != T_PRE + P_CSR) bad_pre++;
        end else begin
          n_ro++;
          if (addr != exp_row) row_err++;
          if (b2b && hi_len != T_PRE + 1) bad_pre++;
          if (last_ro_addr == 8'hFF && addr == 8'h00) seen_wrap = 1;
          last_ro_addr = addr; exp_row = exp_row + 8'd1;
        end
        lo_len = 1; hold = casl_n ? 0 : 1;
      end else begin
        lo_len++; if (!casl_n) hold++;
      end
      if (!in_cbr && (!casl_n || !cash_n)) bad_cas_ro++;
    end else begin
      if (!prev_ras) begin
        if (lo_len != P_RAS) bad_ras++;
        if (in_cbr && hold != P_CHR) bad_hold++;
        hi_len = 1; b2b = bus_req;
      end else hi_len++;
      lead = !casl_n ? lead + 1 : 0;
    end
    prev_ras = ras_n; prev_req = bus_req;
  end

  task automatic step(); @(negedge clk); #2; endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_err++; $display("FAIL %s actual=%0d expected=%0d", rq, act, exp); end
  endtask

  task automatic wait_falls(input int n);
    int target = n_fall + n;
    for (int i = 0; i < 5000 && n_fall < target; i++) step();
  endtask

  task automatic t_params();
    chk(P_RAS * 20 >= 40, "R11 ras low ns", P_RAS * 20, 40);
    chk(T_PRE * 20 >= 30, "R11 precharge ns", T_PRE * 20, 30);
    chk(P_CSR * 20 >= 10 && P_CHR * 20 >= 10, "R11 cas setup/hold ns", P_CSR * 20, 10);
    chk(P_INT * 20 <= 15600, "R11 interval ns", P_INT * 20, 15600);
    chk(P_PAUSE * 20 >= 200000, "R11 pause ns", P_PAUSE * 20, 200000);
  endtask

  task automatic t_pause();
    int early = 0;
    step();
    chk(!ready && !bus_req && ras_n && casl_n, "R1 reset state", {ready, bus_req, ras_n, casl_n}, 4'b0011);
    rst_n = 1;
    for (int i = 1; i <= P_PAUSE; i++) begin
      step();
      if (bus_req || !ras_n || !casl_n || ready) early++;
    end
    chk(early == 0, "R1 quiet pause", early, 0);
    step();
    chk(bus_req == 1, "R1 request after pause", bus_req, 1);
  endtask

  task automatic t_wake();
    int f0 = n_fall, d0 = n_req_drop;
    for (int i = 0; i < 2000 && !ready; i++) step();
    chk(n_fall - f0 == P_WAKE, "R2 wake refresh count", n_fall - f0, P_WAKE);
    chk(n_req_drop - d0 == 1, "R2 request held through burst", n_req_drop - d0, 1);
    chk(bad_pre == 0, "R8 back-to-back precharge", bad_pre, 0);
    chk(bad_ras == 0 && bad_cas_ro == 0, "R6 row-address pulse shape", bad_ras + bad_cas_ro, 0);
    chk(row_err == 0, "R6 row address on pins", row_err, 0);
  endtask

  task automatic t_interval();
    wait_falls(1);
    for (int k = 0; k < 3; k++) begin
      wait_falls(1);
      chk(last_spacing == P_INT, "R3 refresh spacing", last_spacing, P_INT);
    end
  endtask

  task automatic t_cbr();
    int c0;
    cbr_mode = 1;
    wait_falls(1);
    c0 = n_cbr;
    for (int i = 0; i < 5000 && n_cbr < c0 + 3; i++) step();
    wait_falls(1);
    chk(n_cbr - c0 >= 3, "R5 column-first cycles seen", n_cbr - c0, 3);
    chk(bad_lead == 0, "R5 cas setup before ras", bad_lead, 0);
    chk(bad_hold == 0, "R5 cas hold after ras", bad_hold, 0);
    chk(bad_we == 0, "R5 write strobe high", bad_we, 0);
    chk(bad_rpc == 0, "R8 ras high to cas low", bad_rpc, 0);
    chk(bad_ras == 0, "R5 ras low width", bad_ras, 0);
  endtask

  task automatic t_latch();
    int c0, r0, h0;
    for (int i = 0; i < 1000 && !(ras_n && !casl_n); i++) step();
    c0 = n_cbr; r0 = n_ro; h0 = bad_hold;
    cbr_mode = 0;
    for (int i = 0; i < 50 && ras_n; i++) step();
    for (int i = 0; i < 50 && !ras_n; i++) step();
    chk(n_cbr - c0 == 1 && bad_hold == h0, "R10 cycle keeps latched mode", n_cbr - c0, 1);
    wait_falls(1);
    chk(n_ro - r0 == 1, "R10 next cycle uses new mode", n_ro - r0, 1);
    chk(row_err == 0, "R7 counter held during column-first", row_err, 0);
  endtask

  task automatic t_late();
    int f0, d0, k = 0, stuck = 0;
    for (int i = 0; i < 1000 && bus_req; i++) step();
    allow = 0;
    for (int i = 0; i < 1000 && !bus_req; i++) step();
    f0 = n_fall;
    for (int i = 0; i < 50; i++) begin
      step(); k++;
      if (!ras_n || !bus_req) stuck++;
    end
    chk(stuck == 0 && n_fall == f0, "R4 no strobes without grant", stuck, 0);
    for (int i = 0; i < 2 * P_LATE && !late; i++) begin step(); k++; end
    chk(k >= P_LATE - 2 && k <= P_LATE, "R9 late flag timing", k, P_LATE - 1);
    chk(!ready, "R9 ready withdrawn", ready, 0);
    d0 = n_req_drop;
    allow = 1;
    for (int i = 0; i < 2000 && !ready; i++) step();
    chk(n_fall - f0 == P_WAKE, "R9 wake burst repeated", n_fall - f0, P_WAKE);
    chk(n_req_drop - d0 == 1 && !late, "R9 single request and late cleared", n_req_drop - d0, 1);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 300 && !seen_wrap; i++) wait_falls(1);
    chk(seen_wrap, "R7 row counter wraps 255 to 0", seen_wrap, 1);
    chk(row_err == 0, "R7 row sequence", row_err, 0);
  endtask

  initial begin
    t_params();
    t_pause();
    t_wake();
    t_interval();
    t_cbr();
    t_latch();
    t_late();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule